// File: doc/BRIEF.md
# Switch-Selectable LED Blink Generator

This block produces a square wave on a single LED output. The wave runs at one of four fixed blink rates, and all four are derived from one system clock. Four divider channels run side by side at all times, one channel per rate. Two switch inputs pick which divided wave reaches the pin, through a purely combinational selector. An enable input gates the output: while it is low, the LED is held off.

The system clock frequency and the four rates are module parameters. The defaults are a 25 MHz clock and rates of 100 Hz, 50 Hz, 10 Hz and 1 Hz. A simulation can use a much smaller clock value, so that every rate completes many periods in a short run. Each channel holds its level for CLK_HZ/(2*rate) cycles and then inverts it. Every rate therefore has an exact 50% duty cycle.

Top module: `led_blink_gen`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, every divider channel returns to count zero with its wave low, so `led_o` is 0 after that edge. All registers also start at these values at power-up.
- R2: After reset is released, each channel holds its wave level for exactly H = CLK_HZ/(2*rate) clock edges, with a minimum of 1. Its wave after n edges is therefore floor(n/H) mod 2.
- R3: Every complete high run and every complete low run on `led_o` lasts exactly H cycles of the selected rate, which gives a 50% duty cycle.
- R4: The select value {`sel_hi_i`,`sel_lo_i`} maps as follows: 2'b00 selects rate 0 (100 Hz), 2'b01 selects rate 1 (50 Hz), 2'b10 selects rate 2 (10 Hz) and 2'b11 selects rate 3 (1 Hz).
- R5: While `en_i` is 0, `led_o` is 0 for every select value.
- R6: All four channels count on every cycle after reset, whether or not they are selected. After a change of select, the output shows the phase that the newly chosen channel has built up since reset.
- R7: A change on the select inputs reaches `led_o` within the same cycle, with no clock edge between the channels and the pin.
- R8: Raising `en_i` shows the selected channel's current level on `led_o` at once, without any restart of the channel's phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Output enable; 0 holds the LED off |
| sel_hi_i | input | 1 | High bit of the rate select |
| sel_lo_i | input | 1 | Low bit of the rate select |
| led_o | output | 1 | LED drive square wave |

## Verification
The hardest case to reach from the pins is a channel's phase while that channel is not selected. It can only be seen when the select moves onto the channel part-way through the run. The bench keeps its own count of clock edges since reset. Between clock edges it switches the select and the enable across all values, and each time it compares the output with floor(n/H) mod 2 for the newly chosen rate. A scaled-down clock parameter makes the slowest rate complete several full periods, so every high run and low run can be measured end to end.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    localparam int unsigned NUM_RATES = 4;

    // Cycles that one channel holds each level; never below one.
    function automatic int unsigned half_count(input int unsigned clk_hz,
                                               input int unsigned rate_hz);
        int unsigned h;
        h = (rate_hz == 0) ? 1 : clk_hz / (2 * rate_hz);
        return (h == 0) ? 1 : h;
    endfunction

endpackage

// File: rtl/blink_divider.sv
module blink_divider #(
    parameter int unsigned HALF = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic wave_o
);

    localparam int unsigned HALF_C = (HALF < 1) ? 1 : HALF;
    localparam int unsigned CW     = (HALF_C < 2) ? 1 : $clog2(HALF_C);
    localparam logic [CW-1:0] LAST = CW'(HALF_C - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wave;
    } div_state_t;

    div_state_t st_d;
    div_state_t st_q = '0;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.wave = ~st_q.wave;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_o = st_q.wave;

    // R2: the count never reaches the hold length
    a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= LAST);

    // R2: a level change only ever comes together with a wrap to zero
    a_r2_toggle_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.wave != $past(st_q.wave)) |-> (st_q.cnt == '0));

    // R6: the channel advances on every cycle after reset
    a_r6_free_running: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ((st_q.cnt != $past(st_q.cnt)) || (st_q.wave != $past(st_q.wave))));

endmodule

// File: rtl/blink_rate_mux.sv
module blink_rate_mux #(
    parameter int unsigned N  = 4,
    parameter int unsigned SW = 2
) (
    input  logic [N-1:0]  waves_i,
    input  logic [SW-1:0] sel_i,
    input  logic          en_i,
    output logic          led_o
);

    always_comb begin
        led_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel_i == SW'(i)) begin
                led_o = en_i & waves_i[i];
            end
        end
    end

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
    parameter int unsigned CLK_HZ   = 25_000_000,
    parameter int unsigned RATE0_HZ = 100,
    parameter int unsigned RATE1_HZ = 50,
    parameter int unsigned RATE2_HZ = 10,
    parameter int unsigned RATE3_HZ = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic sel_hi_i,
    input  logic sel_lo_i,
    output logic led_o
);

    import led_blink_pkg::*;

    localparam int unsigned N  = NUM_RATES;
    localparam int unsigned SW = $clog2(N);
    localparam int unsigned RATES [N] = '{RATE0_HZ, RATE1_HZ, RATE2_HZ, RATE3_HZ};

    logic [N-1:0]  waves;
    logic [SW-1:0] sel;

    assign sel = {sel_hi_i, sel_lo_i};

    for (genvar g = 0; g < N; g++) begin : g_div
        blink_divider #(
            .HALF(half_count(CLK_HZ, RATES[g]))
        ) i_div (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .wave_o(waves[g])
        );
    end

    blink_rate_mux #(
        .N (N),
        .SW(SW)
    ) i_mux (
        .waves_i(waves),
        .sel_i  (sel),
        .en_i   (en_i),
        .led_o  (led_o)
    );

    // R5: the output stays off while the enable is low
    a_r5_disabled_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> !led_o);

    // R1: the output is off on the cycle after a reset edge
    a_r1_reset_off: assert property (@(posedge clk_i)
        $past(rst_i) |-> !led_o);

endmodule

// File: tb/test_led_blink_gen.sv
module test_led_blink_gen;

    localparam int unsigned CLK_HZ = 2000;
    localparam int H [4] = '{CLK_HZ / 200, CLK_HZ / 100, CLK_HZ / 20, CLK_HZ / 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic sel_hi = 1'b0;
    logic sel_lo = 1'b0;
    logic led;

    int n = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    led_blink_gen #(.CLK_HZ(CLK_HZ)) i_led_blink_gen (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .sel_hi_i(sel_hi),
        .sel_lo_i(sel_lo),
        .led_o   (led)
    );

    function automatic bit exp_led(input int s, input bit e, input int cnt);
        return e && (((cnt / H[s]) % 2) == 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (n=%0d)", req, act, exp, n);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(led == 1'b0, "R1 reset state", led, 0);
        rst = 1'b0;
        en = 1'b1;

        // R2 R3 R4 R6 R7: sweep every select value
        for (int s = 0; s < 4; s++) begin
            bit prev;
            bit started;
            int run;
            @(negedge clk);
            {sel_hi, sel_lo} = 2'(s);
            #1;
            check(led == exp_led(s, 1'b1, n), "R7 R6 select takes effect within the cycle", led, exp_led(s, 1'b1, n));
            prev = led;
            started = 0;
            run = 0;
            for (int i = 0; i < 4 * H[s] + 3; i++) begin
                @(negedge clk);
                check(led == exp_led(s, 1'b1, n), "R2 R4 level vs edge count", led, exp_led(s, 1'b1, n));
                if (led != prev) begin
                    if (started) check(run == H[s], "R3 run length", run, H[s]);
                    started = 1;
                    run = 1;
                end else begin
                    run++;
                end
                prev = led;
            end
        end

        // R5: enable low for every select value
        @(negedge clk);
        en = 1'b0;
        for (int s = 0; s < 4; s++) begin
            {sel_hi, sel_lo} = 2'(s);
            for (int i = 0; i < 2 * H[0] + 5; i++) begin
                @(negedge clk);
                check(led == 1'b0, "R5 disabled output", led, 0);
            end
        end

        // R8: enable shows the running phase at once
        for (int k = 0; k < 6; k++) begin
            int s;
            s = k % 4;
            repeat (H[s] / 2 + 3) @(negedge clk);
            {sel_hi, sel_lo} = 2'(s);
            en = 1'b1;
            #1;
            check(led == exp_led(s, 1'b1, n), "R8 enable restores phase", led, exp_led(s, 1'b1, n));
            en = 1'b0;
            #1;
            check(led == 1'b0, "R5 enable drop within the cycle", led, 0);
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        {sel_hi, sel_lo} = 2'd0;
        en = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check(led == 1'b0, "R1 mid-run reset", led, 0);
        rst = 1'b0;
        for (int i = 0; i < 3 * H[0]; i++) begin
            @(negedge clk);
            check(led == exp_led(0, 1'b1, n), "R1 R2 restart after reset", led, exp_led(0, 1'b1, n));
        end

        finish_run();
    end

endmodule